// File: doc/BRIEF.md
# Register-Mapped Byte SPI Master

This block is a memory-mapped SPI master that moves one byte per transfer, full duplex. Software writes a byte into the transmit register; that write alone launches an 8-bit exchange on the serial pins, most significant bit first. The byte clocked in from the slave during the same exchange is kept in the receive register until the next exchange ends. To read from a slave without sending data, software writes 0x00 and then reads the receive register.

Software controls each chip-select line through a bit in the control register. It polls a ready flag before it writes the next byte and before it reads the received byte. The configuration register holds the clock idle level, the sampling phase and a 5-bit divider code, which sets the serial clock rate from the system clock. The same register holds a flush request bit that clears itself. The byte-length and queue-enable bits always read zero, because only the single-byte mode is built.

The register bus is a plain single-cycle port. Writes take effect on the clock edge where the write enable is high. Read data is combinational from the address.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, control reads 0x0000_0002 (ready set, no chip select enabled), configuration reads 0, receive and transmit registers read 0, every chip-select output is high (inactive) and the serial clock is low.
- R2: A write to byte offset 0x8 launches one exchange that sends bits 7:0 of the written word MSB first. The received byte then reads back in bits 7:0 of offset 0xC, with bits 31:8 zero. Writing 0x00 makes the slave see 0x00.
- R3: Control bit 1 (ready) goes low on the edge that accepts the transmit write and stays low for exactly 16*H clock cycles, where H is the half-period from R8. It then returns high.
- R4: A transmit write that arrives while an exchange is in progress is ignored. The running exchange finishes with its original byte and timing, and no second exchange follows.
- R5: Control bit 16+i drives chip-select output i low while the bit is set, and releases it high when the bit is cleared. The enables read back in the same positions.
- R6: Configuration bit 7 sets the serial clock idle level: 0 idles low, 1 idles high. The pin follows the bit at once while no exchange runs.
- R7: Configuration bit 6 selects the phase. With 0, data is sampled on the first (leading) clock edge of each bit. With 1, data is sampled on the second (trailing) edge, and output data changes on the leading edges. All four polarity and phase combinations exchange bytes correctly.
- R8: Configuration bits 4:0 hold the divider code c. If bit 4 is 0, the divisor is c. If bit 4 is 1, the divisor is twice bits 3:0. A divisor of 0 is treated as 1. Each serial clock half-period lasts H = ceil(divisor/2) system clocks, so code 0x1F gives H = 15.
- R9: Writing 1 to configuration bit 9 sets a flush request. The bit reads 1 for FLUSH_LAT cycles after the write edge and then clears by itself.
- R10: Configuration bits 5 and 17 and all other undefined configuration bits read 0 even when written with 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Byte address; bits 3:2 select the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| csN | output | NUM_CS | Chip-select lines, active low |

## Verification
A behavioural slave on the serial pins checks exchanges with complementary patterns (0xA5 against 0x3C), all-ones against all-zeros, and a receive-only write of 0x00. These show whether the bit order and the full-duplex pairing are right. The same byte pairs run in all four polarity and phase combinations, so a wrong sampling edge or a missing first-bit skip shows up as a one-bit shift in either direction. The length of the busy window is measured for divider codes on both sides of the range boundary, and for 0, 0x10 and 0x1F. This catches a wrong mapping from code to divisor and a wrong rounding of the half-period. A second write made during an exchange checks that only the first byte goes out and that the timing does not stretch.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  localparam int BYTE_W   = 8;
  localparam int EDGES    = 2 * BYTE_W;
  localparam int PRESC_W  = 5;
  localparam int DIV_W    = PRESC_W;
  localparam int HALF_W   = PRESC_W - 1;
  localparam int REG_W    = 32;

  // word index taken from byte address bits 3:2
  localparam logic [1:0] WSEL_CTRL = 2'd0;
  localparam logic [1:0] WSEL_CFG  = 2'd1;
  localparam logic [1:0] WSEL_TX   = 2'd2;
  localparam logic [1:0] WSEL_RX   = 2'd3;

  localparam int READY_BIT   = 1;
  localparam int CS_BASE     = 16;
  localparam int PHA_BIT     = 6;
  localparam int POL_BIT     = 7;
  localparam int FLUSH_BIT   = 9;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic shiftOut;
    logic sample;
    logic toggle;
    logic finish;
  } shift_strobe_t;

  function automatic logic [DIV_W-1:0] divOf(input logic [PRESC_W-1:0] code);
    logic [DIV_W-1:0] d;
    if (code[PRESC_W-1]) d = {code[PRESC_W-2:0], 1'b0};
    else                 d = code;
    if (d == '0) d = DIV_W'(1);
    return d;
  endfunction

  function automatic logic [HALF_W-1:0] halfOf(input logic [PRESC_W-1:0] code);
    logic [DIV_W:0] sum;
    sum = {1'b0, divOf(code)} + (DIV_W+1)'(1);
    return HALF_W'(sum >> 1);
  endfunction

endpackage

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
  import sbm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               txWrite,
  input  logic [PRESC_W-1:0] prescCode,
  input  logic               cpha,
  output shift_strobe_t      stb,
  output logic               ready
);

  localparam int EDGE_W = $clog2(EDGES);

  typedef enum logic {S_IDLE, S_SHIFT} seqState_t;

  seqState_t          state;
  logic [HALF_W-1:0]  halfCnt;
  logic [HALF_W-1:0]  halfLat;
  logic [EDGE_W-1:0]  edgeCnt;
  logic               phaLat;
  logic               start;
  logic               edgeNow;
  logic               lastEdge;
  logic [HALF_W-1:0]  halfNew;

  assign halfNew  = halfOf(prescCode);
  assign start    = txWrite && (state == S_IDLE);
  assign edgeNow  = (state == S_SHIFT) && (halfCnt == '0);
  assign lastEdge = (edgeCnt == EDGE_W'(EDGES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      halfCnt <= '0;
      halfLat <= HALF_W'(1);
      edgeCnt <= '0;
      phaLat  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_SHIFT;
            halfLat <= halfNew;
            halfCnt <= halfNew - HALF_W'(1);
            edgeCnt <= '0;
            phaLat  <= cpha;
          end
        end
        default: begin
          if (edgeNow) begin
            halfCnt <= halfLat - HALF_W'(1);
            edgeCnt <= edgeCnt + EDGE_W'(1);
            if (lastEdge) state <= S_IDLE;
          end else begin
            halfCnt <= halfCnt - HALF_W'(1);
          end
        end
      endcase
    end
  end

  // even edge index = leading edge; phase 0 samples on leading edges
  always_comb begin
    stb          = '0;
    stb.load     = start;
    stb.toggle   = edgeNow;
    stb.sample   = edgeNow && (edgeCnt[0] == phaLat);
    stb.shiftOut = edgeNow && (edgeCnt[0] != phaLat) &&
                   !(phaLat && (edgeCnt == '0));
    stb.finish   = edgeNow && lastEdge;
  end

  assign ready = (state == S_IDLE);

endmodule

// File: rtl/sbm_datapath.sv
module sbm_datapath
  import sbm_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int ADDR_W    = 4,
  parameter int FLUSH_LAT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  input  logic               ready,
  input  shift_strobe_t      stb,
  output logic               txWrite,
  output logic [PRESC_W-1:0] prescCode,
  output logic               cpha,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_CS-1:0]  csN
);

  localparam int FL_W = (FLUSH_LAT > 1) ? $clog2(FLUSH_LAT) : 1;

  logic [1:0]         wordSel;
  logic               ctrlWr;
  logic               cfgWr;
  logic [NUM_CS-1:0]  csEn;
  logic [PRESC_W-1:0] cfgPresc;
  logic               cfgPha;
  logic               cfgPol;
  logic               flushBusy;
  logic [FL_W-1:0]    flushCnt;
  logic [BYTE_W-1:0]  txShift;
  logic [BYTE_W-1:0]  rxShift;
  logic [BYTE_W-1:0]  rxNext;
  logic [BYTE_W-1:0]  rxData;
  logic               sclkPhase;
  logic               unusedBus;

  assign wordSel   = regAddr[3:2];
  assign ctrlWr    = regWrEn && (wordSel == WSEL_CTRL);
  assign cfgWr     = regWrEn && (wordSel == WSEL_CFG);
  assign txWrite   = regWrEn && (wordSel == WSEL_TX);
  assign unusedBus = ^{regAddr, regWdata};

  // control register: chip-select enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       csEn <= '0;
    else if (ctrlWr) csEn <= regWdata[CS_BASE +: NUM_CS];
  end

  // configuration register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPresc <= '0;
      cfgPha   <= 1'b0;
      cfgPol   <= 1'b0;
    end else if (cfgWr) begin
      cfgPresc <= regWdata[PRESC_W-1:0];
      cfgPha   <= regWdata[PHA_BIT];
      cfgPol   <= regWdata[POL_BIT];
    end
  end

  // self-clearing flush request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushBusy <= 1'b0;
      flushCnt  <= '0;
    end else if (cfgWr && regWdata[FLUSH_BIT]) begin
      flushBusy <= 1'b1;
      flushCnt  <= FL_W'(FLUSH_LAT - 1);
    end else if (flushBusy) begin
      if (flushCnt == '0) flushBusy <= 1'b0;
      else                flushCnt  <= flushCnt - FL_W'(1);
    end
  end

  // shifter
  assign rxNext = stb.sample ? {rxShift[BYTE_W-2:0], miso} : rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '0;
      rxShift   <= '0;
      rxData    <= '0;
      sclkPhase <= 1'b0;
    end else begin
      if (stb.load)          txShift <= regWdata[BYTE_W-1:0];
      else if (stb.shiftOut) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      rxShift <= rxNext;
      if (stb.finish) rxData <= rxNext;
      if (stb.toggle) sclkPhase <= ~sclkPhase;
    end
  end

  assign sclk      = sclkPhase ^ cfgPol;
  assign mosi      = txShift[BYTE_W-1];
  assign prescCode = cfgPresc;
  assign cpha      = cfgPha;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csN[i] = ~csEn[i];
  end

  // read mux
  always_comb begin
    regRdata = '0;
    case (wordSel)
      WSEL_CTRL: begin
        regRdata[READY_BIT]         = ready;
        regRdata[CS_BASE +: NUM_CS] = csEn;
      end
      WSEL_CFG: begin
        regRdata[PRESC_W-1:0] = cfgPresc;
        regRdata[PHA_BIT]     = cfgPha;
        regRdata[POL_BIT]     = cfgPol;
        regRdata[FLUSH_BIT]   = flushBusy;
      end
      WSEL_RX:  regRdata[BYTE_W-1:0] = rxData;
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import sbm_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int ADDR_W    = 4,
  parameter int FLUSH_LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN
);

  shift_strobe_t      stb;
  logic               ready;
  logic               txWrite;
  logic [PRESC_W-1:0] prescCode;
  logic               cpha;

  sbm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txWrite   (txWrite),
    .prescCode (prescCode),
    .cpha      (cpha),
    .stb       (stb),
    .ready     (ready)
  );

  sbm_datapath #(
    .NUM_CS    (NUM_CS),
    .ADDR_W    (ADDR_W),
    .FLUSH_LAT (FLUSH_LAT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .ready     (ready),
    .stb       (stb),
    .txWrite   (txWrite),
    .prescCode (prescCode),
    .cpha      (cpha),
    .sclk      (sclk),
    .mosi      (mosi),
    .miso      (miso),
    .csN       (csN)
  );

endmodule

// File: rtl/sbm_checker.sv
module sbm_checker
  import sbm_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              txWrite,
  input logic              ready,
  input shift_strobe_t     stb,
  input logic              sclk,
  input logic [NUM_CS-1:0] csN
);

  logic [4:0] togCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           togCnt <= '0;
    else if (stb.load)   togCnt <= '0;
    else if (stb.toggle) togCnt <= togCnt + 5'd1;
  end

  // R3: an accepted transmit write drops ready on the next cycle
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && ready) |=> !ready);

  // R3: no shifting activity while ready is high
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !(stb.toggle || stb.sample || stb.shiftOut || stb.finish));

  // R4: a transmit write during an exchange never reloads the shifter
  p_busy_ignore_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && !ready) |-> !stb.load);

  // R2: every exchange ends on its sixteenth clock edge
  p_edge_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |-> (togCnt == 5'(EDGES - 1)));

  // R6: serial clock holds still while idle and no register is written
  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(ready) && !$past(regWrEn)) |-> $stable(sclk));

  // R5: chip selects move only after a register write
  p_cs_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrEn) |-> $stable(csN));

endmodule

bind spi_byte_master sbm_checker #(.NUM_CS(NUM_CS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWrEn (regWrEn),
  .txWrite (txWrite),
  .ready   (ready),
  .stb     (stb),
  .sclk    (sclk),
  .csN     (csN)
);

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;

  localparam int NUM_CS    = 4;
  localparam int FLUSH_LAT = 4;
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_CFG  = 4'h4;
  localparam logic [3:0] A_TX   = 4'h8;
  localparam logic [3:0] A_RX   = 4'hC;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [3:0]        regAddr = '0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic              sclk;
  logic              mosi;
  logic              miso;
  logic [NUM_CS-1:0] csN;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // slave model state
  logic [7:0] sOut = '0;
  logic [7:0] sIn  = '0;
  int         sBits = 0;
  bit         armed = 0;
  bit         firstLead = 1;
  bit         cpolB = 0;
  bit         cphaB = 0;

  spi_byte_master #(.NUM_CS(NUM_CS), .ADDR_W(4), .FLUSH_LAT(FLUSH_LAT)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign miso = sOut[7];

  always @(sclk) begin
    if (armed) begin
      if ((sclk != cpolB) != cphaB) begin
        sIn   = {sIn[6:0], mosi};
        sBits = sBits + 1;
      end else begin
        if (!(cphaB && firstLead)) sOut = {sOut[6:0], 1'b0};
        if (sclk != cpolB) firstLead = 0;
      end
    end
  end

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic setMode(input bit pol, input bit pha, input logic [4:0] code);
    busWrite(A_CFG, {24'd0, pol, pha, 1'b0, code});
    cpolB = pol; cphaB = pha;
  endtask

  task automatic waitReady(output int dur, input int startC);
    logic [31:0] r;
    dur = -1;
    for (int i = 0; i < 3000; i++) begin
      busRead(A_CTRL, r);
      if (r[1]) begin dur = cyc - startC; break; end
    end
  endtask

  task automatic armSlave(input logic [7:0] b);
    sOut = b; sIn = '0; sBits = 0; firstLead = 1; armed = 1;
  endtask

  // one exchange: checks R2 data, R3/R8 busy length, R7 for the current mode
  task automatic xferCheck(input string req, input logic [7:0] tx,
                           input logic [7:0] sb, input int expH);
    int startC, dur;
    logic [31:0] r;
    armSlave(sb);
    busWrite(A_TX, {24'hFFFFFF, tx});
    startC = cyc;
    waitReady(dur, startC);
    chkEq({req, " busy length"}, dur, 16 * expH);
    busRead(A_RX, r);
    chkEq({req, " master received"}, r, {24'd0, sb});
    chkEq({req, " slave received"}, {24'd0, sIn}, {24'd0, tx});
    chkEq({req, " slave bit count"}, sBits, 8);
    armed = 0;
  endtask

  task automatic testReset;
    logic [31:0] r;
    busRead(A_CTRL, r); chkEq("R1 ctrl", r, 32'h2);
    busRead(A_CFG, r);  chkEq("R1 cfg", r, 32'h0);
    busRead(A_RX, r);   chkEq("R1 rx", r, 32'h0);
    busRead(A_TX, r);   chkEq("R1 tx", r, 32'h0);
    chkEq("R1 csN", {28'd0, csN}, 32'hF);
    chkEq("R1 sclk", {31'd0, sclk}, 32'h0);
  endtask

  task automatic testPatterns;
    setMode(0, 0, 5'd2);
    xferCheck("R2 a5/3c", 8'hA5, 8'h3C, 1);
    xferCheck("R2 ff/00", 8'hFF, 8'h00, 1);
    xferCheck("R2 00/81 receive-only", 8'h00, 8'h81, 1);
  endtask

  task automatic testModes;
    for (int m = 1; m < 4; m++) begin
      setMode(m[1], m[0], 5'd3);
      xferCheck($sformatf("R7 mode %0d a5/3c", m), 8'hA5, 8'h3C, 2);
      xferCheck($sformatf("R7 mode %0d 81/7e", m), 8'h81, 8'h7E, 2);
    end
  endtask

  task automatic testPrescale;
    setMode(0, 0, 5'd0);  xferCheck("R8 code 00", 8'h5C, 8'hC5, 1);
    setMode(0, 0, 5'd1);  xferCheck("R8 code 01", 8'h12, 8'h34, 1);
    setMode(0, 0, 5'd15); xferCheck("R3 R8 code 0f", 8'h9D, 8'hD9, 8);
    setMode(0, 0, 5'h10); xferCheck("R8 code 10", 8'h66, 8'h99, 1);
    setMode(0, 1, 5'h13); xferCheck("R8 code 13", 8'h0F, 8'hF0, 3);
    setMode(1, 0, 5'h1F); xferCheck("R8 code 1f", 8'hC3, 8'h3C, 15);
  endtask

  task automatic testBusyWrite;
    int startC, dur;
    logic [31:0] r;
    setMode(0, 0, 5'd2);
    armSlave(8'hE7);
    busWrite(A_TX, 32'h5A);
    startC = cyc;
    busWrite(A_TX, 32'h11);
    waitReady(dur, startC);
    chkEq("R4 busy length unchanged", dur, 16);
    chkEq("R4 slave got first byte", {24'd0, sIn}, 32'h5A);
    repeat (40) @(negedge clk);
    chkEq("R4 no second exchange", sBits, 8);
    busRead(A_CTRL, r);
    chkEq("R4 ready stays high", {31'd0, r[1]}, 32'h1);
    busRead(A_RX, r);
    chkEq("R4 rx from first exchange", r, 32'hE7);
    armed = 0;
  endtask

  task automatic testChipSelect;
    logic [31:0] r;
    busWrite(A_CTRL, 32'h0005_0000);
    chkEq("R5 csN active", {28'd0, csN}, 32'hA);
    busRead(A_CTRL, r);
    chkEq("R5 ctrl readback", r, 32'h0005_0002);
    busWrite(A_CTRL, 32'h0);
    chkEq("R5 csN released", {28'd0, csN}, 32'hF);
  endtask

  task automatic testPolarity;
    setMode(1, 0, 5'd2);
    #1 chkEq("R6 idle high", {31'd0, sclk}, 32'h1);
    setMode(0, 0, 5'd2);
    #1 chkEq("R6 idle low", {31'd0, sclk}, 32'h0);
  endtask

  task automatic testFlushAndReserved;
    int startC, dur;
    logic [31:0] r;
    busWrite(A_CFG, 32'hFFFF_FFFF);
    startC = cyc;
    regAddr = A_CFG;
    #1 r = regRdata;
    chkEq("R10 cfg all-ones readback", r, 32'h0000_02DF);
    dur = -1;
    for (int i = 0; i < 100; i++) begin
      busRead(A_CFG, r);
      if (!r[9]) begin dur = cyc - startC; break; end
    end
    chkEq("R9 flush duration", dur, FLUSH_LAT);
    chkEq("R10 cfg after flush", r, 32'h0000_00DF);
    busWrite(A_CFG, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPatterns();
    testModes();
    testPrescale();
    testBusyWrite();
    testChipSelect();
    testPolarity();
    testFlushAndReserved();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule